// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (open-drain clock and data lines, as in the common 400 kHz fast-mode bus). It holds a small file of seven 8-bit configuration bytes, indexed 0 to 6, and shows every byte on a parallel output for the logic it configures. A system clock that runs many times faster than the bus samples both lines. Each line passes through two flops. Start and stop are recognised from data-line edges while the clock line is high. The block pulls the data line low through an output-enable and never drives it high.

A write access is: start, the slave address with the direction bit at 0, a command byte, one or more data bytes, then stop. The command byte must have its top bit set, and its low seven bits give the starting byte index. Each data byte after the first goes to the next index, so two bytes form a word write to index and index+1. A read access sends address and command the same way, then a repeated start, the address with the direction bit at 1, and one or more bytes back from the slave. The master acknowledges every byte it wants followed by another and does not acknowledge the last one. Each completed write to an index from 1 to 6 gives a one-cycle write strobe together with that index.

The state machine has ten states. IDLE waits for a start. ADDR shifts in the address byte. ADDR_ACK acknowledges a match. CMD takes the command byte and CMD_ACK acknowledges it. WDATA and WDATA_ACK take and acknowledge data bytes. RDATA shifts a byte out and RDATA_ACK samples the master's acknowledge. SKIP ignores the bus until the next start or stop. The transitions are as follows. A start moves every state to ADDR, and a stop moves every state to IDLE. ADDR moves to ADDR_ACK on a match and to SKIP otherwise. ADDR_ACK moves to CMD for a write and to RDATA for a read. CMD moves to CMD_ACK when the top bit is set and to SKIP when it is clear. CMD_ACK moves to WDATA. WDATA and WDATA_ACK alternate. RDATA moves to RDATA_ACK. RDATA_ACK moves back to RDATA on an acknowledge and to SKIP on a missing acknowledge.

Top module: `twowire_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are 11010 followed by strap_i[1:0] (0x6A with strap 2'b10). Any other address is not acknowledged, and every byte after it is left unacknowledged and has no effect until the next start.
- R2: A command byte with bit 7 = 1 is acknowledged and loads bits 6:0 as the byte index. A command byte with bit 7 = 0 is not acknowledged, and the rest of the access is ignored.
- R3: A data byte written to index 1..6 is acknowledged and stored. In the same clock cycle that cfg_o shows the new value, wr_stb_o is high for one cycle and wr_idx_o holds the index.
- R4: Every further data byte in one write access goes to the next index, so a two-byte write updates index and index+1.
- R5: A read returns the byte at the current index MSB first on the data line. A master acknowledge moves on to the next index and its byte. A missing acknowledge ends the read, and the data line is released.
- R6: After reset, bytes 1..6 are 0x20, 0x30, 0x00, 0x30, 0xFF, 0xF0, byte 0 reads 0xC3, and sda_oe_o is low.
- R7: Byte 0 always holds the identity value 0xC3, and bit 6 of byte 5 always keeps its value. Writes to them are acknowledged, but they change nothing, and a write to index 0 gives no strobe.
- R8: Writes to indices above 6 are acknowledged and dropped, and they give no strobe. Reads from such indices return 0x00.
- R9: A stop at any point, including in the middle of a byte, returns the slave to idle without a register write. A repeated start begins a new address phase.
- R10: sda_oe_o changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Low two bits of the slave address |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| cfg_o | output | 56 | Configuration bytes, byte k at bits 8k+7:8k |
| wr_stb_o | output | 1 | One-cycle pulse for each stored register write |
| wr_idx_o | output | 7 | Index of the byte written with wr_stb_o |

## Verification
A bit counter that drifts by one shows within a single byte. The acknowledge falls on the wrong clock pulse, so the master sees a missing acknowledge, or the read data comes back shifted by one bit. A wrong index pointer shows on cfg_o in the same cycle as the write strobe, or in the first byte read back. A protection mask or range decode that is off shows as a changed cfg_o byte or as an extra strobe at the end of the byte concerned. A state machine that misses a stop or a start shows on the next access, because that access then gets no acknowledge.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } slv_state_e;

    // Power-on value of configuration byte k (byte 0 is the fixed identity).
    function automatic logic [7:0] cfg_reset(input int k);
        case (k)
            1:       return 8'h20;
            2:       return 8'h30;
            3:       return 8'h00;
            4:       return 8'h30;
            5:       return 8'hFF;
            6:       return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    // Bits of byte k that a bus write may change.
    function automatic logic [7:0] cfg_wmask(input int k);
        return (k == 5) ? 8'hBF : 8'hFF;
    endfunction

endpackage

// File: rtl/cfgslv_linesync.sv
module cfgslv_linesync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = 3;

    logic [DEPTH-1:0] scl_p;
    logic [DEPTH-1:0] sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[DEPTH-2:0], scl_i};
            sda_p <= {sda_p[DEPTH-2:0], sda_i};
        end
    end

    assign scl_lvl   = scl_p[1];
    assign sda_lvl   = sda_p[1];
    assign scl_rise  = scl_p[1] & ~scl_p[2];
    assign scl_fall  = ~scl_p[1] & scl_p[2];
    assign start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
    assign stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];

endmodule

// File: rtl/cfgslv_regs.sv
module cfgslv_regs
    import cfgslv_pkg::*;
#(
    parameter int          NREG    = 7,
    parameter int          IDXW    = 7,
    parameter logic [7:0]  ID_BYTE = 8'hC3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_o
);

    for (genvar k = 0; k < NREG; k++) begin : g_byte
        if (k == 0) begin : g_id
            assign regs_o[7:0] = ID_BYTE;
        end else begin : g_rw
            localparam logic [7:0] RST = cfg_reset(k);
            localparam logic [7:0] WM  = cfg_wmask(k);
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= RST;
                end else if (wr_en && (wr_idx == IDXW'(k))) begin
                    q <= (q & ~WM) | (wr_data & WM);
                end
            end
            assign regs_o[8*k +: 8] = q;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NREG; k++) begin
            if (int'(rd_idx) == k) rd_data = regs_o[8*k +: 8];
        end
    end

    AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) >= NREG)) |=> $stable(regs_o))
        else $error("out-of-range write changed a register"); // R8

endmodule

// File: rtl/twowire_cfg_slave.sv
module twowire_cfg_slave
    import cfgslv_pkg::*;
#(
    parameter logic [4:0] DEV_ADDR_HI = 5'b11010,
    parameter logic [7:0] ID_BYTE     = 8'hC3,
    parameter int         NREG        = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] cfg_o,
    output logic              wr_stb_o,
    output logic [6:0]        wr_idx_o
);
    localparam int         IDXW    = 7;
    localparam logic [3:0] BITS    = 4'd8;
    localparam logic [6:0] IDX_TOP = '1;

    logic scl_s, scl_rise, scl_fall, sda_s, start_det, stop_det;

    cfgslv_linesync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_s),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    slv_state_e      state_q, state_d;
    logic [3:0]      cnt_q;
    logic [7:0]      rx_q, tx_q;
    logic            rw_q, oe_q, stb_q;
    logic [IDXW-1:0] ptr_q, stb_idx_q;
    logic [7:0]      rd_data;
    logic            byte_done, addr_hit, wr_req, in_byte, rx_state;

    assign byte_done = scl_fall && (cnt_q == BITS);
    assign addr_hit  = (rx_q[7:1] == {DEV_ADDR_HI, strap_i});
    assign wr_req    = (state_q == ST_WDATA) && (state_d == ST_WDATA_ACK);
    assign in_byte   = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                       (state_q == ST_WDATA) || (state_q == ST_RDATA);
    assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                       (state_q == ST_WDATA);

    cfgslv_regs #(.NREG(NREG), .IDXW(IDXW), .ID_BYTE(ID_BYTE)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_req),
        .wr_idx (ptr_q),
        .wr_data(rx_q),
        .rd_idx (ptr_q),
        .rd_data(rd_data),
        .regs_o (cfg_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: state_d = state_q;
                ST_ADDR:      if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall)  state_d = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_done) state_d = rx_q[7] ? ST_CMD_ACK : ST_SKIP;
                ST_CMD_ACK:   if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:     if (byte_done) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: begin
                    if (scl_rise && sda_s) state_d = ST_SKIP;
                    else if (scl_fall)     state_d = ST_RDATA;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            rw_q      <= 1'b0;
            ptr_q     <= '0;
            oe_q      <= 1'b0;
            stb_q     <= 1'b0;
            stb_idx_q <= '0;
        end else begin
            stb_q <= 1'b0;
            if ((state_d != state_q) || start_det) cnt_q <= '0;
            else if (scl_rise && in_byte)          cnt_q <= cnt_q + 4'd1;

            if (scl_rise && rx_state) rx_q <= {rx_q[6:0], sda_s};

            if ((state_q == ST_ADDR) && (state_d == ST_ADDR_ACK)) rw_q <= rx_q[0];
            if ((state_q == ST_CMD) && (state_d == ST_CMD_ACK))   ptr_q <= rx_q[6:0];

            if (wr_req) begin
                if ((ptr_q != '0) && (int'(ptr_q) < NREG)) begin
                    stb_q     <= 1'b1;
                    stb_idx_q <= ptr_q;
                end
                if (ptr_q != IDX_TOP) ptr_q <= ptr_q + 7'd1;
            end
            if ((state_q == ST_RDATA) && (state_d == ST_RDATA_ACK) && (ptr_q != IDX_TOP))
                ptr_q <= ptr_q + 7'd1;

            if (state_d != state_q) begin
                unique case (state_d)
                    ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: oe_q <= 1'b1;
                    ST_RDATA: begin
                        oe_q <= ~rd_data[7];
                        tx_q <= {rd_data[6:0], 1'b0};
                    end
                    default: oe_q <= 1'b0;
                endcase
            end else if ((state_q == ST_RDATA) && scl_fall) begin
                oe_q <= ~tx_q[7];
                tx_q <= {tx_q[6:0], 1'b0};
            end
        end
    end

    assign sda_oe_o = oe_q;
    assign wr_stb_o = stb_q;
    assign wr_idx_o = stb_idx_q;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q != $past(oe_q)) |-> !scl_s)
        else $error("data drive changed while clock high"); // R10
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !oe_q)
        else $error("data line driven while ignoring bus"); // R1
    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR))
        else $error("start did not open address phase"); // R9
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> ((state_q == ST_IDLE) && !oe_q))
        else $error("stop did not return to idle"); // R9
    AST_STB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> ((wr_idx_o != '0) && (int'(wr_idx_o) < NREG)))
        else $error("strobe for a protected or absent index"); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= BITS)
        else $error("bit counter past one byte"); // R5

endmodule

// File: tb/twowire_cfg_slave_bench.sv
module twowire_cfg_slave_bench;
    localparam int Q    = 8;
    localparam int NVEC = 6;
    // {index, byte count, data0, data1, expected0, expected1}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'h01, 8'd1, 8'hA5, 8'h00, 8'hA5, 8'h00},
        {8'h03, 8'd2, 8'h12, 8'h34, 8'h12, 8'h34},
        {8'h05, 8'd1, 8'h00, 8'h00, 8'h40, 8'h00},
        {8'h00, 8'd1, 8'h00, 8'h00, 8'hC3, 8'h00},
        {8'h06, 8'd2, 8'h5A, 8'hFF, 8'h5A, 8'h00},
        {8'h02, 8'd2, 8'h81, 8'h7E, 8'h81, 8'h7E}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        m_scl, m_sda;
    logic [1:0]  strap;
    logic        sda_oe;
    logic [55:0] cfg;
    logic        wr_stb;
    logic [6:0]  wr_idx;
    logic        sda_line;

    int total = 0;
    int bad = 0;
    int stb_n = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    twowire_cfg_slave u_twowire_cfg_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_line),
        .strap_i (strap),
        .sda_oe_o(sda_oe),
        .cfg_o   (cfg),
        .wr_stb_o(wr_stb),
        .wr_idx_o(wr_idx)
    );

    always @(posedge clk) begin
        if (wr_stb) stb_n++;
        if ((sda_oe !== oe_prev) && m_scl) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [7:0] cfg_byte(input int k);
        return cfg[8*k +: 8];
    endfunction

    function automatic string vtag(input int v);
        case (v)
            0:       return "R3";
            1:       return "R4";
            2:       return "R7";
            3:       return "R7";
            4:       return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = (sda_line == 1'b0);
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic last);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            m_scl = 1'b0;
        end
        tick(1);
        m_sda = last; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0;
        if (!last) m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, output logic [3:0] acks);
        bus_start();
        send_byte({a, 1'b0}, acks[0]);
        send_byte(cmd, acks[1]);
        send_byte(d0, acks[2]);
        if (n > 1) send_byte(d1, acks[3]);
        else acks[3] = 1'b1;
        bus_stop();
        tick(2);
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] cmd, input int n,
                           output logic [7:0] r0, output logic [7:0] r1, output logic [2:0] acks);
        bus_start();
        send_byte({a, 1'b0}, acks[0]);
        send_byte(cmd, acks[1]);
        bus_start();
        send_byte({a, 1'b1}, acks[2]);
        recv_byte(r0, (n == 1));
        if (n > 1) recv_byte(r1, 1'b1);
        else r1 = 8'h00;
        bus_stop();
        tick(2);
    endtask

    logic [3:0] wacks;
    logic [2:0] racks;
    logic [7:0] rb0, rb1, off, ex0, ex1, nb;
    logic       a0, a1, a2;
    int         s0, exp_stb;
    logic [55:0] snap;

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        wrap_up();
    end

    initial begin
        m_scl = 1'b1; m_sda = 1'b1; strap = 2'b10; rst_n = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R6: reset image and idle data line
        chk("R6 reset cfg", 32'(cfg[55:32]), 32'h00F0FF30);
        chk("R6 reset cfg", cfg[31:0], 32'h003020C3);
        chk("R6 reset sda_oe", 32'(sda_oe), 32'h0);
        do_read(7'h6A, 8'h84, 1, rb0, rb1, racks);
        chk("R6 bus read of byte4", 32'(rb0), 32'h30);

        // Vector table: write then read back with a repeated start
        for (int v = 0; v < NVEC; v++) begin
            off = VEC[v][47:40]; nb = VEC[v][39:32];
            ex0 = VEC[v][15:8];  ex1 = VEC[v][7:0];
            s0 = stb_n;
            exp_stb = 0;
            for (int i = 0; i < int'(nb); i++)
                if ((int'(off) + i >= 1) && (int'(off) + i <= 6)) exp_stb++;
            do_write(7'h6A, 8'h80 | off, int'(nb), VEC[v][31:24], VEC[v][23:16], wacks);
            chk({vtag(v), " write acks"}, 32'(wacks), 32'hF);
            chk({vtag(v), " strobe count"}, 32'(stb_n - s0), 32'(exp_stb));
            for (int i = 0; i < int'(nb); i++)
                if (int'(off) + i <= 6)
                    chk({vtag(v), " cfg_o byte"}, 32'(cfg_byte(int'(off) + i)), 32'((i == 0) ? ex0 : ex1));
            do_read(7'h6A, 8'h80 | off, int'(nb), rb0, rb1, racks);
            chk({vtag(v), " read acks"}, 32'(racks), 32'h7);
            chk({vtag(v), " R5 read byte0"}, 32'(rb0), 32'(ex0));
            if (nb == 8'd2) chk({vtag(v), " R5 read byte1"}, 32'(rb1), 32'(ex1));
            chk("R5 line released after read", 32'(sda_oe), 32'h0);
        end

        // R1: address mismatch, following bytes ignored
        s0 = stb_n; snap = cfg;
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h81, a1);
        send_byte(8'h00, a2);
        bus_stop();
        chk("R1 mismatch addr ack", 32'(a0), 32'h0);
        chk("R1 ignored cmd ack", 32'(a1), 32'h0);
        chk("R1 ignored data ack", 32'(a2), 32'h0);
        chk("R1 cfg unchanged", 32'(cfg == snap), 32'h1);
        chk("R1 no strobe", 32'(stb_n - s0), 32'h0);

        // R1: strap bits form the low address bits
        strap = 2'b01;
        tick(4);
        do_write(7'h69, 8'h81, 1, 8'h3C, 8'h00, wacks);
        chk("R1 strap address acks", 32'(wacks), 32'hF);
        chk("R1 strap address write", 32'(cfg_byte(1)), 32'h3C);
        strap = 2'b10;
        tick(4);

        // R2: command without bit 7 is refused
        s0 = stb_n;
        bus_start();
        send_byte(8'hD4, a0);
        send_byte(8'h01, a1);
        send_byte(8'h55, a2);
        bus_stop();
        chk("R2 addr ack", 32'(a0), 32'h1);
        chk("R2 bad cmd nack", 32'(a1), 32'h0);
        chk("R2 data after bad cmd nack", 32'(a2), 32'h0);
        chk("R2 byte1 kept", 32'(cfg_byte(1)), 32'h3C);
        chk("R2 no strobe", 32'(stb_n - s0), 32'h0);

        // R8: far index write dropped, far read returns zero
        s0 = stb_n; snap = cfg;
        do_write(7'h6A, 8'hC0, 1, 8'h77, 8'h00, wacks);
        chk("R8 far write acks", 32'(wacks), 32'hF);
        chk("R8 far write no strobe", 32'(stb_n - s0), 32'h0);
        chk("R8 far write cfg unchanged", 32'(cfg == snap), 32'h1);
        do_read(7'h6A, 8'hFF, 1, rb0, rb1, racks);
        chk("R8 far read value", 32'(rb0), 32'h00);

        // R9: stop in the middle of a data byte
        s0 = stb_n;
        bus_start();
        send_byte(8'hD4, a0);
        send_byte(8'h81, a1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        tick(2);
        chk("R9 partial byte no strobe", 32'(stb_n - s0), 32'h0);
        chk("R9 partial byte byte1 kept", 32'(cfg_byte(1)), 32'h3C);
        chk("R9 idle after stop", 32'(sda_oe), 32'h0);
        do_read(7'h6A, 8'h81, 1, rb0, rb1, racks);
        chk("R9 next access acks", 32'(racks), 32'h7);
        chk("R9 next access data", 32'(rb0), 32'h3C);

        // R10: drive changes only with the clock line low
        chk("R10 drive change while clock high", 32'(oe_viol), 32'h0);

        wrap_up();
    end

endmodule